// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block recovers a vertical sync from a composite sync stream, such as sync sliced from a video channel. Once the composite sync is synchronized to the system clock, the block measures each low and each high stretch of it in ticks of a 5 MHz enable. The separated vertical sync changes state only when a stretch lasts long enough. A low stretch that reaches the programmed threshold drives the output high. A high stretch that reaches the threshold drives it low again. Horizontal sync pulses and equalization pulses are short, so with a threshold set above their widths they never move the output.

Two activity monitors watch the separated vertical sync and a dedicated vertical sync pin. Each one reports activity while edges keep arriving and drops the report after a programmable number of ticks without an edge. A source flag picks the dedicated pin whenever that pin is active and falls back to the separator otherwise. The selected signal appears on the main vertical sync output.

Top module: `csep_top`

## Requirements
- R1: While reset is asserted and in the cycle after it, `vsync_out`, `sep_vsync`, `vs_present` and `vs_src` are all 0.
- R2: After reset the threshold is 32 ticks (0x20). A low stretch of 29 ticks leaves `sep_vsync` at 0 and a low stretch of 36 ticks sets it to 1.
- R3: `sep_vsync` is active high. It rises only after the synchronized composite sync has stayed low for at least the threshold number of ticks, and the tick counter restarts on every edge of the composite sync. Short low pulses (4 ticks) with a default threshold never raise it.
- R4: `sep_vsync` falls only after the composite sync has stayed high for at least the threshold number of ticks. A high stretch shorter than the threshold leaves it at 1.
- R5: A cycle with `thr_we` = 1 loads `thr_wdata` as the new threshold. Without `thr_we` the threshold keeps its value.
- R6: The interval counter stops at 255 and does not wrap, so a threshold of 255 still works and a low stretch longer than 256 ticks keeps `sep_vsync` at 1.
- R7: `vs_present` becomes 1 after an edge of the separated vertical sync (or of an active pin). It returns to 0 once TIMEOUT_TICKS ticks pass with no edge from either source.
- R8: `vs_src` is 1 (separator) when the separator is active and the pin is not. It is 0 (pin) whenever the pin is active. `vsync_out` follows the selected source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_5m | input | 1 | One-cycle enable at 5 MHz, the measuring timebase |
| csync_in | input | 1 | Composite sync, active low, asynchronous |
| vsync_pin_in | input | 1 | Dedicated vertical sync pin, asynchronous |
| thr_we | input | 1 | Threshold load strobe |
| thr_wdata | input | 8 | Threshold value in ticks |
| vsync_out | output | 1 | Vertical sync from the selected source |
| sep_vsync | output | 1 | Vertical sync recovered from composite sync, active high |
| vs_present | output | 1 | A vertical sync source is active |
| vs_src | output | 1 | 1 = separator drives vsync_out, 0 = pin |

## Verification
The separator is driven with several patterns. A run of short low pulses with long high gaps, like horizontal lines, shows that narrow pulses are rejected. Low stretches just under and just over the default threshold pin down where that threshold sits. High stretches of both kinds separate the deassert rule from the assert rule. A reprogrammed small threshold shows that the comparison follows the register, and a maximal threshold with a very long stretch covers the counter's upper limit. A quiet period longer than the timeout, followed by a toggling pin, distinguishes the presence timeout from the source selection.

// File: rtl/csep_pkg.sv
package csep_pkg;

    // Width of the interval counter and of the threshold register.
    localparam int unsigned CNT_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    // Threshold after reset: 32 ticks of the 5 MHz timebase.
    localparam cnt_t THR_DEFAULT = cnt_t'(8'h20);

    // Largest value the interval counter may hold.
    localparam cnt_t CNT_MAX = '1;

    // State of the interval measuring separator.
    typedef struct packed {
        logic prev;   // level seen in the previous cycle
        cnt_t cnt;    // ticks elapsed since the last edge
        logic vs;     // separated vertical sync
    } sep_state_t;

    // State held at the top level.
    typedef struct packed {
        cnt_t thr;    // programmed threshold
        logic src;    // 1 = separator selected
        logic pres;   // any source active
        logic out;    // selected vertical sync
    } top_state_t;

endpackage

// File: rtl/csep_sync.sv
module csep_sync #(
    parameter int unsigned        STAGES  = 2,
    parameter int unsigned        WIDTH   = 1,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    // Each stage takes the value of the one before it.
    always_comb begin
        stg_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[g] <= RST_VAL;
            end else begin
                stg_q[g] <= stg_d[g];
            end
        end
    end

    assign q_out = stg_q[STAGES-1];

endmodule

// File: rtl/csep_width.sv
module csep_width
    import csep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lvl_in,   // synchronized composite sync
    input  cnt_t thr,
    output logic vs_out
);

    sep_state_t st_d, st_q;
    logic       chg_s;     // edge of the composite sync in this cycle
    logic       hit_s;     // current stretch has reached the threshold

    always_comb begin
        st_d      = st_q;
        chg_s     = (lvl_in != st_q.prev);
        st_d.prev = lvl_in;

        // The count belongs to the stretch that is still running, so an
        // edge cycle never compares.
        hit_s = !chg_s && (st_q.cnt >= thr);

        if (chg_s) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + cnt_t'(1);
        end

        // A long low stretch asserts, a long high stretch deasserts.
        if (hit_s) begin
            st_d.vs = ~lvl_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.cnt  <= '0;
            st_q.vs   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vs_out = st_q.vs;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && lvl_in == st_q.prev) |=> (st_q.cnt == CNT_MAX)); // R6

    AST_RESTART_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_in != st_q.prev) |=> (st_q.cnt == '0)); // R3

    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.vs) |-> ($past(lvl_in) == 1'b0 && $past(st_q.cnt) >= $past(thr))); // R3

    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.vs) |-> ($past(lvl_in) == 1'b1 && $past(st_q.cnt) >= $past(thr))); // R4

endmodule

// File: rtl/csep_activity.sv
module csep_activity #(
    parameter int unsigned TIMEOUT = 500000,   // ticks without an edge
    parameter logic        RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sig_in,
    output logic present
);

    localparam int unsigned   TW      = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT - 1);

    typedef struct packed {
        logic          prev;
        logic          present;
        logic [TW-1:0] cnt;
    } act_state_t;

    act_state_t st_d, st_q;
    logic       chg_s;

    always_comb begin
        st_d      = st_q;
        chg_s     = (sig_in != st_q.prev);
        st_d.prev = sig_in;

        if (chg_s) begin
            st_d.present = 1'b1;
            st_d.cnt     = '0;
        end else if (tick && st_q.present) begin
            if (st_q.cnt == TO_LAST) begin
                st_d.present = 1'b0;
                st_d.cnt     = '0;
            end else begin
                st_d.cnt = st_q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev    <= RST_LVL;
            st_q.present <= 1'b0;
            st_q.cnt     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign present = st_q.present;

    AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_in != st_q.prev) |=> st_q.present); // R7

    AST_DROP_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.present) |-> ($past(st_q.cnt) == TO_LAST && $past(sig_in) == $past(st_q.prev))); // R7

endmodule

// File: rtl/csep_top.sv
module csep_top
    import csep_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 500000,  // about 100 ms of 5 MHz ticks
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_5m,
    input  logic             csync_in,
    input  logic             vsync_pin_in,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_wdata,
    output logic             vsync_out,
    output logic             sep_vsync,
    output logic             vs_present,
    output logic             vs_src
);

    top_state_t st_d, st_q;

    logic [1:0] sync_s;
    logic       csync_s;
    logic       pin_s;
    logic       sep_vs;
    logic       sep_act;
    logic       pin_act;

    // Bit 0 composite sync (idles high), bit 1 dedicated pin (idles low).
    csep_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (2),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({vsync_pin_in, csync_in}),
        .q_out (sync_s)
    );

    assign csync_s = sync_s[0];
    assign pin_s   = sync_s[1];

    csep_width u_sep (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_5m),
        .lvl_in (csync_s),
        .thr    (st_q.thr),
        .vs_out (sep_vs)
    );

    csep_activity #(
        .TIMEOUT (TIMEOUT_TICKS),
        .RST_LVL (1'b0)
    ) u_act_sep (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_5m),
        .sig_in  (sep_vs),
        .present (sep_act)
    );

    csep_activity #(
        .TIMEOUT (TIMEOUT_TICKS),
        .RST_LVL (1'b0)
    ) u_act_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_5m),
        .sig_in  (pin_s),
        .present (pin_act)
    );

    always_comb begin
        st_d = st_q;
        if (thr_we) begin
            st_d.thr = thr_wdata;
        end
        // The pin wins whenever it toggles; the separator is the fallback.
        st_d.src  = sep_act && !pin_act;
        st_d.pres = sep_act || pin_act;
        st_d.out  = st_d.src ? sep_vs : pin_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.thr  <= THR_DEFAULT;
            st_q.src  <= 1'b0;
            st_q.pres <= 1'b0;
            st_q.out  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vsync_out  = st_q.out;
    assign sep_vsync  = sep_vs;
    assign vs_present = st_q.pres;
    assign vs_src     = st_q.src;

    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_we |=> $stable(st_q.thr)); // R5

    AST_THR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        thr_we |=> (st_q.thr == $past(thr_wdata))); // R5

    AST_SRC_NEEDS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        vs_src |-> vs_present); // R8

    AST_PIN_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
        pin_act |=> !vs_src); // R8

endmodule

// File: tb/csep_top_bench.sv
module csep_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int TO_TICKS   = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       csync = 1'b1;
    logic       vpin = 1'b0;
    logic       thr_we = 1'b0;
    logic [7:0] thr_wd = 8'h00;
    logic       vsync_out, sep_vsync, vs_present, vs_src;
    int         tdiv = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    csep_top #(
        .TIMEOUT_TICKS (TO_TICKS),
        .SYNC_STAGES   (2)
    ) u_csep_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_5m      (tick),
        .csync_in     (csync),
        .vsync_pin_in (vpin),
        .thr_we       (thr_we),
        .thr_wdata    (thr_wd),
        .vsync_out    (vsync_out),
        .sep_vsync    (sep_vsync),
        .vs_present   (vs_present),
        .vs_src       (vs_src)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
        tick <= (tdiv == 0);
    end

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int nticks);
        @(negedge clk);
        csync = lvl;
        repeat (nticks*TICK_DIV) @(negedge clk);
    endtask

    task automatic write_thr(input logic [7:0] v);
        @(negedge clk);
        thr_we = 1'b1;
        thr_wd = v;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(vsync_out, 1'b0, "R1", "vsync_out in reset");
        check(sep_vsync, 1'b0, "R1", "sep_vsync in reset");
        check(vs_present, 1'b0, "R1", "vs_present in reset");
        check(vs_src, 1'b0, "R1", "vs_src in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(sep_vsync, 1'b0, "R1", "sep_vsync after reset");
        check(vs_present, 1'b0, "R1", "vs_present after reset");
    endtask

    task automatic t_hsync_only;
        for (int i = 0; i < 5; i++) begin
            hold(1'b0, 4);
            check(sep_vsync, 1'b0, "R3", "short low pulse");
            hold(1'b1, 60);
        end
        check(vs_present, 1'b0, "R7", "no separated edge yet");
    endtask

    task automatic t_default_thr;
        hold(1'b0, 29);
        check(sep_vsync, 1'b0, "R2", "29-tick low under default");
        hold(1'b1, 10);
        hold(1'b0, 36);
        check(sep_vsync, 1'b1, "R2", "36-tick low over default");
        check(vs_present, 1'b1, "R7", "present after separated edge");
        check(vs_src, 1'b1, "R8", "separator selected");
        check(vsync_out, 1'b1, "R8", "vsync_out follows separator");
    endtask

    task automatic t_deassert;
        hold(1'b1, 10);
        check(sep_vsync, 1'b1, "R4", "short high keeps vsync");
        hold(1'b0, 5);
        hold(1'b1, 40);
        check(sep_vsync, 1'b0, "R4", "long high clears vsync");
        check(vsync_out, 1'b0, "R8", "vsync_out cleared");
    endtask

    task automatic t_thr_write;
        write_thr(8'd10);
        hold(1'b0, 7);
        check(sep_vsync, 1'b0, "R5", "7 ticks under threshold 10");
        hold(1'b1, 4);
        hold(1'b0, 14);
        check(sep_vsync, 1'b1, "R5", "14 ticks over threshold 10");
        hold(1'b1, 7);
        check(sep_vsync, 1'b1, "R5", "7-tick high under threshold 10");
        hold(1'b0, 3);
        hold(1'b1, 14);
        check(sep_vsync, 1'b0, "R5", "14-tick high over threshold 10");
    endtask

    task automatic t_saturate;
        write_thr(8'd255);
        hold(1'b0, 250);
        check(sep_vsync, 1'b0, "R6", "250 ticks under 255");
        hold(1'b0, 20);
        check(sep_vsync, 1'b1, "R6", "270 ticks reaches 255");
        hold(1'b0, 100);
        check(sep_vsync, 1'b1, "R6", "370 ticks still asserted");
        hold(1'b1, 270);
        check(sep_vsync, 1'b0, "R6", "long high at 255 clears");
        write_thr(8'd32);
    endtask

    task automatic t_timeout;
        hold(1'b0, 40);
        check(vs_present, 1'b1, "R7", "present after new frame");
        hold(1'b1, 200);
        check(vs_present, 1'b1, "R7", "present inside timeout");
        hold(1'b1, 180);
        check(vs_present, 1'b0, "R7", "absent after timeout");
        check(vs_src, 1'b0, "R8", "no source once absent");
    endtask

    task automatic t_source;
        hold(1'b0, 40);
        check(vs_src, 1'b1, "R8", "separator alone selected");
        check(vsync_out, sep_vsync, "R8", "vsync_out equals sep_vsync");
        hold(1'b1, 60);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            vpin = ~vpin;
            repeat (20*TICK_DIV) @(negedge clk);
            check(vs_src, 1'b0, "R8", "active pin selected");
            check(vsync_out, vpin, "R8", "vsync_out follows pin");
            check(vs_present, 1'b1, "R7", "present with active pin");
        end
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        t_hsync_only();
        t_default_thr();
        t_deassert();
        t_thr_write();
        t_saturate();
        t_timeout();
        t_source();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule